// File: doc/BRIEF.md
# Tone-Processor Control Register Target

This block is the write-only two-wire serial bus target of an audio tone and volume processor. It oversamples the clock line and the data line with the system clock, filters short glitches, and detects START and STOP conditions. It then decodes the transfers that a bus controller sends to it and places the received settings in a bank of eight 8-bit control registers. The register contents drive the analog control logic as parallel outputs.

A transfer is a START, then the device address byte, then a subaddress byte, then any number of data bytes, then a STOP. The subaddress gives the register pointer and a stepping flag. With the flag clear, every data byte lands in the same register. With it set, each byte goes one register further, and the 4-bit pointer loops from 15 back to 0. Pointer values 8 to 15 name no register, so data bytes aimed at them are acknowledged and then dropped. The block answers only with acknowledge pulses on an open-drain output enable. It never stretches the clock and cannot be read.

The register outputs are plain levels, valid in every cycle. No valid/ready handshake is needed at any edge of this block, because the bank accepts every write in the cycle it arrives and the bus side has no back-pressure.

Top module: `tonectl_i2c_regs`

## Requirements
- R1: After reset, the registers hold these values: reg0 (input select) = 0x01 (second input), reg1 (input gain) = 0x0E (28 dB), reg2 (volume) = 0x30 (mute), reg3 (bass) = 0x07 (0 dB), reg4 (treble) = 0x08 (+2 dB), reg5 and reg6 (speaker attenuators) = 0x50 (mute), and reg7 = 0x00. Register n appears on `reg_q[8n+7:8n]`, and `sda_oe` is low.
- R2: Only the address byte 0x88 (7-bit address 0x44 with the write bit 0) is acknowledged. Any other address byte, including 0x89, gets no acknowledge. In that case every later byte is ignored and left unacknowledged until the next START.
- R3: `sda_oe` rises only while SCL is low and stays high through the whole high phase of the ninth clock. It is released after the falling SCL edge that ends the ninth clock, so the line is free before the next bit.
- R4: In the subaddress byte, bits 3..0 are the register pointer, bit 4 is the stepping flag, and bits 7..5 have no effect. The subaddress byte and every data byte of an addressed transfer are acknowledged.
- R5: With the stepping flag at 0, every data byte of the transfer is written to the selected register, so the last byte sent is the value that remains.
- R6: With the stepping flag at 1, the first data byte goes to the sent pointer. Each later byte goes to the pointer plus one, modulo 16.
- R7: Data bytes aimed at pointer values 8 to 15 are acknowledged and change no register.
- R8: A START or STOP that arrives before the eighth bit of a byte has been clocked abandons that byte, and nothing is written.
- R9: A repeated START without a STOP begins a new address match, and then a new subaddress.
- R10: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Data bits are taken on the rising SCL edge, and SDA changes while SCL is low never end a transfer.
- R11: A pulse on SCL that lasts fewer than FILT_LEN system clocks (3 by default) is not treated as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| reg_q | output | 64 | Eight control registers, register n in bits 8n+7..8n |

## Verification
A register write and a pointer step can fall in the same clock edge. The bank takes the byte at the old pointer on the same edge that the stepping logic advances the pointer. This matters most when the pointer leaves the range of real registers, and again when it wraps from 15 to 0. The case is provoked by a stepping transfer of twelve bytes that starts at register 6, so it crosses 7→8, runs through the dropped window, and wraps. The result is judged by comparing all eight registers with a bench model that places each byte by the pointer rule. Checker properties also require each step to be exactly plus one, and require no register to change without a write to a real register.

// File: rtl/tonectl_pkg.sv
package tonectl_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_f
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      line_f   <= 1'b1;
      hold_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_f) begin
        hold_cnt <= '0;
      end else if (hold_cnt == CW'(FILT_LEN - 1)) begin
        line_f   <= sync_q[1];
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tonectl_bus_rx.sv
module tonectl_bus_rx
  import tonectl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              autoinc,
  output logic              bus_evt
);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [3:0]        LAST_BIT  = 4'd8;

  phase_t            phase;
  logic              scl_q, sda_q;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              in_ack;
  logic              scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign bus_evt   = start_det | stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      in_ack  <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_ptr  <= '0;
      wr_data <= '0;
      autoinc <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (wr_en && autoinc) begin
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (start_det) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !in_ack && bit_cnt != LAST_BIT) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_f};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            unique case (phase)
              PH_ADDR: phase <= PH_SUB;
              PH_SUB:  phase <= PH_DATA;
              default: phase <= PH_DATA;
            endcase
          end else if (bit_cnt == LAST_BIT) begin
            unique case (phase)
              PH_ADDR: begin
                if (shreg == ADDR_BYTE) begin
                  in_ack <= 1'b1;
                  sda_oe <= 1'b1;
                end else begin
                  phase   <= PH_IDLE;
                  bit_cnt <= '0;
                end
              end
              PH_SUB: begin
                wr_ptr  <= shreg[PTR_W-1:0];
                autoinc <= shreg[4];
                in_ack  <= 1'b1;
                sda_oe  <= 1'b1;
              end
              default: begin
                wr_en   <= 1'b1;
                wr_data <= shreg;
                in_ack  <= 1'b1;
                sda_oe  <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/tonectl_regbank.sv
module tonectl_regbank
  import tonectl_pkg::*;
#(
  parameter int                    NREG       = 8,
  parameter logic [8*NREG-1:0]     RESET_VALS = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_ptr,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [BYTE_W*NREG-1:0] reg_q
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[BYTE_W*gi +: BYTE_W] <= RESET_VALS[BYTE_W*gi +: BYTE_W];
      end else if (wr_en && wr_ptr == PTR_W'(gi)) begin
        reg_q[BYTE_W*gi +: BYTE_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tonectl_i2c_regs.sv
module tonectl_i2c_regs
  import tonectl_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR   = 7'h44,
  parameter int                NUM_REGS   = 8,
  parameter int                FILT_LEN   = 3,
  parameter logic [63:0]       RESET_VALS = 64'h00_50_50_08_07_30_0E_01
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [BYTE_W*NUM_REGS-1:0] reg_q
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_flt;
  logic              scl_f, sda_f;
  logic              wr_en, autoinc, bus_evt;
  logic [PTR_W-1:0]  wr_ptr;
  logic [BYTE_W-1:0] wr_data;

  assign line_raw = {sda_i, scl_i};

  for (genvar gl = 0; gl < NLINES; gl++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_raw[gl]),
      .line_f (line_flt[gl])
    );
  end

  assign scl_f = line_flt[0];
  assign sda_f = line_flt[1];

  tonectl_bus_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .autoinc (autoinc),
    .bus_evt (bus_evt)
  );

  tonectl_regbank #(
    .NREG       (NUM_REGS),
    .RESET_VALS (RESET_VALS[BYTE_W*NUM_REGS-1:0])
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .reg_q   (reg_q)
  );
endmodule

// File: rtl/tonectl_i2c_regs_chk.sv
module tonectl_i2c_regs_chk #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_oe,
  input logic              bus_evt,
  input logic              wr_en,
  input logic              autoinc,
  input logic [3:0]        wr_ptr,
  input logic [8*NREG-1:0] reg_q
);
  // R3: pull-down begins only while the filtered clock is low
  a_r3_ack_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R3: release happens with SCL low, unless a bus condition forced it
  a_r3_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_f || $past(bus_evt)));

  // R3: pull-down held while SCL is high in the ninth clock
  a_r3_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && scl_f && !bus_evt) |=> sda_oe);

  // R5: fixed mode keeps the pointer after a write
  a_r5_fixed_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !autoinc) |=> $stable(wr_ptr));

  // R6: stepping mode advances by one, wrapping at 16
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && autoinc) |=> (wr_ptr == 4'($past(wr_ptr) + 4'd1)));

  // R7: a register only changes after a write to an existing register
  a_r7_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_q) |-> ($past(wr_en) && ($past(wr_ptr) < 4'(NREG))));
endmodule

bind tonectl_i2c_regs tonectl_i2c_regs_chk #(.NREG(NUM_REGS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_f   (scl_f),
  .sda_oe  (sda_oe),
  .bus_evt (bus_evt),
  .wr_en   (wr_en),
  .autoinc (autoinc),
  .wr_ptr  (wr_ptr),
  .reg_q   (reg_q)
);

// File: tb/tonectl_i2c_regs_test.sv
`timescale 1ns/1ps
module tonectl_i2c_regs_test;
  localparam int Q = 20;
  localparam logic [63:0] DEFAULTS = 64'h00_50_50_08_07_30_0E_01;
  localparam int NVEC = 7;
  // each entry: {subaddress, data}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h02_15, 16'hE3_0A, 16'h04_0C, 16'h09_AA, 16'h0F_55, 16'h07_3C, 16'hA0_02
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [63:0] reg_q;
  logic [7:0] mdl [8];
  logic glitch_en = 1'b0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  tonectl_i2c_regs uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_drv),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .reg_q  (reg_q)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) chk(tag, reg_q[8*i +: 8], mdl[i]);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wclk(Q);
    scl_drv = 1'b1; wclk(Q);
    sda_drv = 1'b0; wclk(Q);
    scl_drv = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wclk(Q);
    scl_drv = 1'b1; wclk(Q);
    sda_drv = 1'b1; wclk(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_drv = b[i]; wclk(Q);
      scl_drv = 1'b1; wclk(Q);
      if (glitch_en) begin
        scl_drv = 1'b0; wclk(1);
        scl_drv = 1'b1; wclk(Q - 1);
      end else begin
        wclk(Q);
      end
      scl_drv = 1'b0; wclk(Q);
    end
  endtask

  // sends a full byte, checks acknowledge against expectation (R2/R4) and release (R3)
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic acked;
    send_bits(b, 8);
    sda_drv = 1'b1; wclk(Q);
    scl_drv = 1'b1; wclk(Q);
    acked = sda_oe;
    chk(tag, {63'd0, acked}, {63'd0, exp_ack});
    wclk(Q);
    scl_drv = 1'b0; wclk(Q);
    if (exp_ack) chk("R3 release after ninth clock", {63'd0, sda_oe}, 64'd0);
  endtask

  task automatic model_write(input logic [3:0] p, input logic [7:0] d);
    if (!p[3]) mdl[p[2:0]] = d;
  endtask

  task automatic load_defaults();
    for (int i = 0; i < 8; i++) mdl[i] = DEFAULTS[8*i +: 8];
  endtask

  initial begin
    load_defaults();
    wclk(5);
    // R1: reset state
    check_all("R1 reset value");
    chk("R1 sda_oe idle", {63'd0, sda_oe}, 64'd0);
    rst_n = 1'b1;
    wclk(5);
    check_all("R1 after reset release");

    // table walk: single-byte writes, R4 field decode, R7 drop, R10 framing
    for (int v = 0; v < NVEC; v++) begin
      bus_start();
      send_byte(8'h88, 1'b1, "R2 address ack");
      send_byte(VEC[v][15:8], 1'b1, "R4 subaddress ack");
      send_byte(VEC[v][7:0], 1'b1, "R7 data ack");
      bus_stop();
      model_write(VEC[v][11:8], VEC[v][7:0]);
      wclk(4);
      check_all("R4/R7/R10 table");
    end

    // R2: wrong address, then bytes ignored
    bus_start();
    send_byte(8'h8A, 1'b0, "R2 foreign address nack");
    send_byte(8'h02, 1'b0, "R2 ignored after nack");
    send_byte(8'h77, 1'b0, "R2 ignored after nack");
    bus_stop();
    wclk(4);
    check_all("R2 no write after nack");
    bus_start();
    send_byte(8'h89, 1'b0, "R2 read bit nack");
    bus_stop();

    // R5: fixed mode, several bytes to one register
    bus_start();
    send_byte(8'h88, 1'b1, "R5 address ack");
    send_byte(8'h01, 1'b1, "R5 sub ack");
    send_byte(8'h11, 1'b1, "R5 data ack");
    send_byte(8'h22, 1'b1, "R5 data ack");
    send_byte(8'h33, 1'b1, "R5 data ack");
    bus_stop();
    model_write(4'h1, 8'h33);
    wclk(4);
    check_all("R5 last byte wins");

    // R6/R7: stepping from 6 across the dropped window and wrap
    bus_start();
    send_byte(8'h88, 1'b1, "R6 address ack");
    send_byte(8'h16, 1'b1, "R6 sub ack");
    for (int k = 0; k < 12; k++) begin
      send_byte(8'h60 + 8'(k), 1'b1, "R7 stepping data ack");
      model_write(4'(6 + k), 8'h60 + 8'(k));
    end
    bus_stop();
    wclk(4);
    check_all("R6 stepping with wrap");

    // R8: STOP mid-byte
    bus_start();
    send_byte(8'h88, 1'b1, "R8 address ack");
    send_byte(8'h02, 1'b1, "R8 sub ack");
    send_bits(8'hFF, 4);
    bus_stop();
    wclk(4);
    check_all("R8 stop aborts byte");

    // R8/R9: START mid-byte, then new address and subaddress
    bus_start();
    send_byte(8'h88, 1'b1, "R9 address ack");
    send_byte(8'h03, 1'b1, "R9 sub ack");
    send_bits(8'hC3, 5);
    bus_start();
    send_byte(8'h88, 1'b1, "R9 address after restart");
    send_byte(8'h04, 1'b1, "R9 new sub ack");
    send_byte(8'h44, 1'b1, "R9 data ack");
    bus_stop();
    model_write(4'h4, 8'h44);
    wclk(4);
    check_all("R8 start aborts byte");

    // R9: repeated START between complete bytes
    bus_start();
    send_byte(8'h88, 1'b1, "R9 address ack");
    send_byte(8'h05, 1'b1, "R9 sub ack");
    send_byte(8'h51, 1'b1, "R9 data ack");
    bus_start();
    send_byte(8'h88, 1'b1, "R9 readdress ack");
    send_byte(8'h13, 1'b1, "R9 resub ack");
    send_byte(8'hA1, 1'b1, "R9 data ack");
    send_byte(8'hA2, 1'b1, "R9 data ack");
    bus_stop();
    model_write(4'h5, 8'h51);
    model_write(4'h3, 8'hA1);
    model_write(4'h4, 8'hA2);
    wclk(4);
    check_all("R9 repeated start");

    // R11: one-cycle SCL glitches inside each high phase
    glitch_en = 1'b1;
    bus_start();
    send_byte(8'h88, 1'b1, "R11 address ack");
    send_byte(8'h00, 1'b1, "R11 sub ack");
    send_byte(8'h5A, 1'b1, "R11 data ack");
    glitch_en = 1'b0;
    bus_stop();
    model_write(4'h0, 8'h5A);
    wclk(4);
    check_all("R11 glitch filtered");

    // R1: reset again restores defaults
    rst_n = 1'b0;
    wclk(3);
    load_defaults();
    check_all("R1 second reset");
    rst_n = 1'b1;
    wclk(3);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule